// File: doc/BRIEF.md
# Bus Idle-Time Gate for a Single-Wire Control Bus

This block decides when a transmitter may begin driving a shared single-wire control bus. After an arming event it counts half-bit-period ticks. It raises a ready flag once the bus has stayed quiet for the programmed idle time.

The idle time comes from a 3-bit code. Each nonzero code selects a fixed number of half-bit ticks. Code zero selects a protocol default, and that default depends on why the device wants the bus: a retry after a failed attempt, a new initiator, or the same initiator sending its next frame. A start-option input picks the arming event: a software transmit request, or the end of any message seen on the bus.

Bus activity during counting cancels the count. Counting then resumes at the next end-of-message pulse. Once ready is raised it stays high until the transmitter reports that a transmission has actually started.

Top module: `bus_idle_gate`

## Requirements
- R1: After a synchronous reset (rst high at a clock edge), ready and busy are both 0.
- R2: With a nonzero code n on idle_code at the arming edge, ready rises at the clock edge of the (2n−1)-th counted half_tick after arming (code 1 gives 1 tick, code 7 gives 13).
- R3: With idle_code 0, the target is taken from dflt_sel: 2'b00 (same initiator, next frame) gives 14 ticks, 2'b01 (new initiator) gives 10 ticks, and 2'b10 or 2'b11 (retry) gives 6 ticks.
- R4: With auto_start 0, a tx_req pulse arms counting and a msg_end pulse is ignored (busy stays 0).
- R5: With auto_start 1, a msg_end pulse arms counting and a tx_req pulse is ignored (busy stays 0).
- R6: line_busy high during counting clears the count, drops busy and keeps ready low. Counting restarts from zero only at the next msg_end pulse, whatever the start option.
- R7: Once high, ready holds through ticks and arming pulses until tx_start is sampled high, and it is 0 in the following cycle. tx_start has no effect while ready is low.
- R8: busy is 1 from the edge that samples an arming pulse until ready rises or counting is cancelled.
- R9: An arming pulse during counting restarts the count from zero and latches the current code.
- R10: ready and busy are never high together.
- R11: Clock cycles without half_tick make no progress toward ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| half_tick | input | 1 | One-cycle pulse per half nominal bit period |
| idle_code | input | 3 | Idle-time code, 0 selects the default |
| dflt_sel | input | 2 | Default kind: 00 next frame, 01 new initiator, 1x retry |
| auto_start | input | 1 | 0: arm on tx_req, 1: arm on msg_end |
| tx_req | input | 1 | Transmit-start request pulse |
| msg_end | input | 1 | End-of-message pulse from transmitter or receiver |
| line_busy | input | 1 | Bus activity seen |
| tx_start | input | 1 | Transmission has actually begun |
| ready | output | 1 | Idle time elapsed, transmitter may start |
| busy | output | 1 | Idle-time count in progress |

## Verification
A wrong count or a wrongly latched target shows up as ready rising one or more half-tick periods early or late. The scoreboard compares the counted ticks at every rising edge of ready, so the error is caught at that edge. A wrong state shows up within one cycle: busy changes when an ignored pulse arrives, busy stays high after a cancel, or ready falls without tx_start. The bench probes each of these cases right after the stimulus that could cause it.

// File: rtl/bus_idle_pkg.sv
package bus_idle_pkg;

  typedef enum logic [1:0] {
    GATE_IDLE  = 2'd0,
    GATE_COUNT = 2'd1,
    GATE_HOLD  = 2'd2,
    GATE_READY = 2'd3
  } gate_state_t;

  localparam logic [1:0] DSEL_NEXT  = 2'b00;
  localparam logic [1:0] DSEL_NEW   = 2'b01;

endpackage

// File: rtl/idle_target_decode.sv
module idle_target_decode #(
  parameter int CODE_W        = 3,
  parameter int CNT_W         = 5,
  parameter int DFLT_NEXT_HT  = 14,
  parameter int DFLT_NEW_HT   = 10,
  parameter int DFLT_RETRY_HT = 6
) (
  input  logic [CODE_W-1:0] code,
  input  logic [1:0]        dflt_sel,
  output logic [CNT_W-1:0]  target
);
  import bus_idle_pkg::*;

  localparam logic [CNT_W-1:0] T_NEXT  = CNT_W'(DFLT_NEXT_HT);
  localparam logic [CNT_W-1:0] T_NEW   = CNT_W'(DFLT_NEW_HT);
  localparam logic [CNT_W-1:0] T_RETRY = CNT_W'(DFLT_RETRY_HT);

  // nonzero code n -> 2n-1 half-bit ticks; zero -> protocol default
  always_comb begin
    if (code == '0) begin
      case (dflt_sel)
        DSEL_NEXT: target = T_NEXT;
        DSEL_NEW:  target = T_NEW;
        default:   target = T_RETRY;
      endcase
    end else begin
      target = CNT_W'({code, 1'b0}) - CNT_W'(1);
    end
  end

endmodule

// File: rtl/arm_event_select.sv
module arm_event_select (
  input  logic auto_start,
  input  logic holding,
  input  logic tx_req,
  input  logic msg_end,
  output logic arm
);
  // after a cancel only end-of-message re-arms; otherwise the option decides
  always_comb begin
    if (holding)         arm = msg_end;
    else if (auto_start) arm = msg_end;
    else                 arm = tx_req;
  end

endmodule

// File: rtl/half_tick_counter.sv
module half_tick_counter #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             step,
  input  logic [CNT_W-1:0] target,
  output logic             hit
);
  logic [CNT_W-1:0] count;

  always_ff @(posedge clk) begin
    if (rst || clear) count <= '0;
    else if (step)    count <= count + CNT_W'(1);
  end

  assign hit = step && ((count + CNT_W'(1)) == target);

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    count <= target); // R2

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (rst)
    clear |=> (count == '0)); // R9

endmodule

// File: rtl/bus_idle_gate.sv
module bus_idle_gate #(
  parameter int CODE_W        = 3,
  parameter int CNT_W         = 5,
  parameter int DFLT_NEXT_HT  = 14,
  parameter int DFLT_NEW_HT   = 10,
  parameter int DFLT_RETRY_HT = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              half_tick,
  input  logic [CODE_W-1:0] idle_code,
  input  logic [1:0]        dflt_sel,
  input  logic              auto_start,
  input  logic              tx_req,
  input  logic              msg_end,
  input  logic              line_busy,
  input  logic              tx_start,
  output logic              ready,
  output logic              busy
);
  import bus_idle_pkg::*;

  gate_state_t      state_q, state_d;
  logic [CNT_W-1:0] target_q, target_dec;
  logic             arm, arm_take, cancel, clear_cnt, step, hit;

  idle_target_decode #(
    .CODE_W(CODE_W), .CNT_W(CNT_W),
    .DFLT_NEXT_HT(DFLT_NEXT_HT), .DFLT_NEW_HT(DFLT_NEW_HT),
    .DFLT_RETRY_HT(DFLT_RETRY_HT)
  ) u_decode (
    .code(idle_code), .dflt_sel(dflt_sel), .target(target_dec)
  );

  arm_event_select u_arm (
    .auto_start(auto_start), .holding(state_q == GATE_HOLD),
    .tx_req(tx_req), .msg_end(msg_end), .arm(arm)
  );

  // arming is ignored once ready is up
  assign arm_take  = arm && (state_q != GATE_READY);
  assign cancel    = (state_q == GATE_COUNT) && !arm && line_busy;
  assign clear_cnt = arm_take || cancel;
  assign step      = (state_q == GATE_COUNT) && half_tick && !arm && !line_busy;

  half_tick_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .clear(clear_cnt), .step(step),
    .target(target_q), .hit(hit)
  );

  always_comb begin
    state_d = state_q;
    case (state_q)
      GATE_IDLE:  if (arm_take) state_d = GATE_COUNT;
      GATE_COUNT: begin
        if (arm_take)    state_d = GATE_COUNT;
        else if (cancel) state_d = GATE_HOLD;
        else if (hit)    state_d = GATE_READY;
      end
      GATE_HOLD:  if (arm_take) state_d = GATE_COUNT;
      GATE_READY: if (tx_start) state_d = GATE_IDLE;
      default:    state_d = GATE_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= GATE_IDLE;
      target_q <= '0;
      ready    <= 1'b0;
      busy     <= 1'b0;
    end else begin
      state_q <= state_d;
      if (arm_take) target_q <= target_dec;
      ready   <= (state_d == GATE_READY);
      busy    <= (state_d == GATE_COUNT);
    end
  end

  AST_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(ready && busy)); // R10

  AST_READY_HOLD: assert property (@(posedge clk) disable iff (rst)
    (ready && !tx_start) |=> ready); // R7

  AST_READY_DROP: assert property (@(posedge clk) disable iff (rst)
    (ready && tx_start) |=> !ready); // R7

  AST_READY_FROM_COUNT: assert property (@(posedge clk) disable iff (rst)
    (!busy && !ready) |=> !ready); // R8

  AST_NO_TICK_NO_READY: assert property (@(posedge clk) disable iff (rst)
    (busy && !half_tick) |=> !ready); // R11

  AST_CANCEL: assert property (@(posedge clk) disable iff (rst)
    (busy && line_busy && !arm) |=> (!busy && !ready)); // R6

endmodule

// File: tb/bus_idle_gate_tb.sv
`timescale 1ns/100ps
module bus_idle_gate_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       half_tick = 1'b0;
  logic [2:0] idle_code = 3'd0;
  logic [1:0] dflt_sel = 2'b00;
  logic       auto_start = 1'b0;
  logic       tx_req = 1'b0;
  logic       msg_end = 1'b0;
  logic       line_busy = 1'b0;
  logic       tx_start = 1'b0;
  logic       ready, busy;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  bit mon_en = 1'b0;
  int exp_q[$];

  always #2 clk = ~clk;

  bus_idle_gate u_dut (
    .clk(clk), .rst(rst), .half_tick(half_tick), .idle_code(idle_code),
    .dflt_sel(dflt_sel), .auto_start(auto_start), .tx_req(tx_req),
    .msg_end(msg_end), .line_busy(line_busy), .tx_start(tx_start),
    .ready(ready), .busy(busy)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_ticks(input int code, input int sel);
    if (code != 0) return 2 * code - 1;
    if (sel == 0) return 14;
    if (sel == 1) return 10;
    return 6;
  endfunction

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic pulse_req();  tx_req = 1'b1;    cyc(); tx_req = 1'b0;    endtask
  task automatic pulse_end();  msg_end = 1'b1;   cyc(); msg_end = 1'b0;   endtask
  task automatic pulse_go();   tx_start = 1'b1;  cyc(); tx_start = 1'b0;  endtask
  task automatic pulse_line(); line_busy = 1'b1; cyc(); line_busy = 1'b0; endtask

  task automatic one_tick();
    half_tick = 1'b1; cyc(); half_tick = 1'b0; cyc(); cyc();
  endtask

  task automatic ticks_until_ready();
    for (int i = 0; i < 20; i++) begin
      if (ready) break;
      one_tick();
    end
  endtask

  // driver: one complete frame, pushes its expected tick count
  task automatic run_frame(input bit use_end, input int code, input int sel, input string req);
    idle_code = 3'(code);
    dflt_sel  = 2'(sel);
    exp_q.push_back(exp_ticks(code, sel));
    if (use_end) pulse_end(); else pulse_req();
    check(busy == 1'b1, "R8 busy after arm", busy, 1);
    ticks_until_ready();
    check(ready == 1'b1, req, ready, 1);
    pulse_go();
    check(ready == 1'b0, "R7 ready drop after tx_start", ready, 0);
  endtask

  // monitor: counts ticks while counting and compares at each ready rise
  int  mon_ticks = 0;
  bit  prev_ready = 1'b0;
  always @(negedge clk) begin
    if (mon_en) begin
      if (ready && !prev_ready) begin
        check(busy == 1'b0, "R10 ready with busy", busy, 0);
        if (exp_q.size() == 0) begin
          check(1'b0, "R2 unexpected ready rise", mon_ticks, -1);
        end else begin
          int e;
          e = exp_q.pop_front();
          check(mon_ticks == e, "R2/R3 ticks to ready", mon_ticks, e);
        end
      end
      prev_ready = ready;
      if (!busy) mon_ticks = 0;
      else if (auto_start ? msg_end : tx_req) mon_ticks = 0;
      else if (line_busy) mon_ticks = 0;
      else if (half_tick) mon_ticks++;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) cyc();
    rst = 1'b0;
    cyc();
    check(ready == 1'b0 && busy == 1'b0, "R1 reset state", {ready, busy}, 0);
    mon_en = 1'b1;

    // R4: option 0 ignores msg_end
    auto_start = 1'b0;
    pulse_end();
    check(busy == 1'b0, "R4 msg_end ignored", busy, 0);

    // R2: every nonzero code, software start
    for (int c = 1; c < 8; c++) run_frame(1'b0, c, 0, "R2 ready after coded time");

    // R3: defaults
    for (int s = 0; s < 4; s++) run_frame(1'b0, 0, s, "R3 ready after default time");

    // R7: tx_start while counting ignored, ready holds through ticks and arming
    idle_code = 3'd2;
    exp_q.push_back(3);
    pulse_req();
    pulse_go();
    check(busy == 1'b1 && ready == 1'b0, "R7 tx_start ignored when not ready", busy, 1);
    ticks_until_ready();
    one_tick(); one_tick();
    pulse_req(); pulse_end();
    check(ready == 1'b1 && busy == 1'b0, "R7 ready holds", ready, 1);
    pulse_go();
    check(ready == 1'b0, "R7 ready drop", ready, 0);

    // R11: no progress without ticks
    idle_code = 3'd3;
    exp_q.push_back(5);
    pulse_req();
    one_tick(); one_tick();
    repeat (30) cyc();
    check(ready == 1'b0 && busy == 1'b1, "R11 no progress without ticks", ready, 0);
    ticks_until_ready();
    check(ready == 1'b1, "R11 completes after ticks", ready, 1);
    pulse_go();

    // R9: re-arm mid count restarts with new code
    idle_code = 3'd4;
    pulse_req();
    one_tick(); one_tick(); one_tick();
    idle_code = 3'd2;
    exp_q.push_back(3);
    pulse_req();
    one_tick(); one_tick();
    check(ready == 1'b0, "R9 restart not early", ready, 0);
    ticks_until_ready();
    check(ready == 1'b1, "R9 ready after restart", ready, 1);
    pulse_go();

    // R6: line activity cancels; tx_req ignored; msg_end restarts
    idle_code = 3'd3;
    pulse_req();
    one_tick(); one_tick();
    pulse_line();
    check(busy == 1'b0 && ready == 1'b0, "R6 cancel on line activity", busy, 0);
    one_tick(); one_tick(); one_tick(); one_tick();
    pulse_req();
    check(busy == 1'b0 && ready == 1'b0, "R6 held until msg_end", busy, 0);
    exp_q.push_back(5);
    pulse_end();
    check(busy == 1'b1, "R6 restart on msg_end", busy, 1);
    ticks_until_ready();
    check(ready == 1'b1, "R6 ready after restart", ready, 1);
    pulse_go();

    // R5: option 1 ignores tx_req and arms on msg_end
    auto_start = 1'b1;
    pulse_req();
    check(busy == 1'b0, "R5 tx_req ignored", busy, 0);
    run_frame(1'b1, 1, 0, "R5 auto start code 1");
    run_frame(1'b1, 0, 1, "R5 auto start default new");

    cyc(); cyc();
    check(exp_q.size() == 0, "R2 scoreboard drained", exp_q.size(), 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule